// File: doc/BRIEF.md
# Protection Region Bounds Decoder

This block turns the address-match settings of a bank of memory protection entries into explicit inclusive byte ranges. Each entry supplies a two-bit match mode and an address word that holds byte address bits shifted right by two. For every entry the block produces a start byte address, an end byte address and an enable flag. With these, a downstream access checker needs only two magnitude compares per entry and no knowledge of the match modes.

Four match modes are handled. A disabled entry yields no range. In top-of-range mode the lower bound comes from the preceding entry's address word. A four-byte mode covers one naturally aligned word. In naturally aligned power-of-two mode the size is encoded by the run of trailing ones in the address word. The block also reports how many entries are enabled. The outputs are two bits wider than the address word, so a region reaching the top of the space never wraps. All outputs are registered and follow any change of mode or address one clock later. Mode and address are register state rather than a data stream, so the pins are plain levels with no handshake. Nothing ever stalls the block.

Top module: `region_bounds_dec`

## Requirements
- R1: Entry i's mode sits in `ent_mode[2i+1:2i]` and is encoded as 0 = disabled, 1 = top-of-range, 2 = four-byte, 3 = power-of-two. A disabled entry drives its enable low and its start and end to zero.
- R2: A top-of-range entry spans from the previous entry's address word times 4 to its own address word times 4 minus 1. For entry 0 the previous word is taken as zero.
- R3: A top-of-range entry whose previous address word is greater than or equal to its own drives start and end to zero and keeps its enable high.
- R4: A four-byte entry starts at its address word times 4 and ends 3 bytes later.
- R5: A power-of-two entry whose address word ends in k ones (k >= 0) above a zero covers 8·2^k bytes, aligned to that size, and contains the address word times 4.
- R6: Start and end are AW+2 bits wide. A power-of-two entry whose address word has only ones, or only a single leading zero, covers the whole space from 0 to 2^(AW+2)-1.
- R7: `rule_cnt` equals the number of entries whose mode is not disabled.
- R8: Outputs change exactly one rising clock edge after the mode and address inputs change, and hold between edges.
- R9: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ent_mode | input | 2*NENT | Per-entry match mode, entry i at bits [2i+1:2i] |
| ent_addr | input | NENT*AW | Per-entry address word (byte address >> 2), entry i at bits [i*AW +: AW] |
| rgn_lo | output | NENT*(AW+2) | Per-entry inclusive start byte address |
| rgn_hi | output | NENT*(AW+2) | Per-entry inclusive end byte address |
| rgn_on | output | NENT | Per-entry enable (mode not disabled) |
| rule_cnt | output | $clog2(NENT+1) | Count of enabled entries |

## Verification
The assertions rely on the mode and address inputs holding known values from the end of reset onward and changing only between clock edges. Each one-cycle-delayed property can then compare the registered ranges with the inputs seen at the previous edge. The bench keeps to this: it drives defined values before releasing reset and changes inputs only on falling edges. A small build of four entries with six-bit address words lets the bench cycle through every combination of the four modes, each with many address patterns. Those patterns cover every trailing-ones length, empty and non-empty top-of-range pairs, and the all-ones word.

// File: rtl/rbd_pkg.sv
package rbd_pkg;

  typedef enum logic [1:0] {
    MODE_OFF   = 2'd0,
    MODE_TOR   = 2'd1,
    MODE_NA4   = 2'd2,
    MODE_NAPOT = 2'd3
  } match_mode_e;

  localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/rbd_napot_span.sv
module rbd_napot_span #(
  parameter int unsigned AW = 32,
  localparam int unsigned BW = AW + 2
) (
  input  logic [AW-1:0] word,
  output logic [BW-1:0] lo,
  output logic [BW-1:0] hi
);
  // Append two ones. The carry of t+1 then ripples through the trailing
  // ones, so AND clears them (aligned base) and OR fills them (last byte).
  logic [BW-1:0] t;
  logic [BW-1:0] t_inc;

  assign t     = {word, 2'b11};
  assign t_inc = t + BW'(1);
  assign lo    = t & t_inc;
  assign hi    = t | t_inc;
endmodule

// File: rtl/rbd_tor_span.sv
module rbd_tor_span #(
  parameter int unsigned AW = 32,
  localparam int unsigned BW = AW + 2
) (
  input  logic [AW-1:0] prev_word,
  input  logic [AW-1:0] own_word,
  output logic [BW-1:0] lo,
  output logic [BW-1:0] hi
);
  // Compare the words themselves: prev >= own means start > end in bytes
  // (R3). This also avoids the underflow of own*4-1 when own is zero.
  logic empty;

  assign empty = (prev_word >= own_word);

  always_comb begin
    if (empty) begin
      lo = '0;
      hi = '0;
    end else begin
      lo = {prev_word, 2'b00};
      hi = {own_word, 2'b00} - BW'(1);
    end
  end
endmodule

// File: rtl/rbd_entry_dec.sv
module rbd_entry_dec
  import rbd_pkg::*;
#(
  parameter int unsigned AW = 32,
  localparam int unsigned BW = AW + 2
) (
  input  logic [MODE_W-1:0] mode,
  input  logic [AW-1:0]     own_word,
  input  logic [AW-1:0]     prev_word,
  output logic [BW-1:0]     lo,
  output logic [BW-1:0]     hi,
  output logic              on
);
  logic [BW-1:0] tor_lo, tor_hi;
  logic [BW-1:0] pot_lo, pot_hi;
  logic [BW-1:0] na4_lo;

  rbd_tor_span #(.AW(AW)) u_tor (
    .prev_word (prev_word),
    .own_word  (own_word),
    .lo        (tor_lo),
    .hi        (tor_hi)
  );

  rbd_napot_span #(.AW(AW)) u_pot (
    .word (own_word),
    .lo   (pot_lo),
    .hi   (pot_hi)
  );

  assign na4_lo = {own_word, 2'b00};

  always_comb begin
    on = 1'b1;
    lo = '0;
    hi = '0;
    case (match_mode_e'(mode))
      MODE_TOR: begin
        lo = tor_lo;
        hi = tor_hi;
      end
      MODE_NA4: begin
        lo = na4_lo;
        hi = na4_lo | BW'(3);
      end
      MODE_NAPOT: begin
        lo = pot_lo;
        hi = pot_hi;
      end
      default: begin
        on = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/rbd_rule_count.sv
module rbd_rule_count #(
  parameter int unsigned NENT = 16,
  localparam int unsigned CW = $clog2(NENT + 1)
) (
  input  logic [NENT-1:0] on,
  output logic [CW-1:0]   cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < NENT; i++) begin
      cnt = cnt + CW'(on[i]);
    end
  end
endmodule

// File: rtl/region_bounds_dec.sv
module region_bounds_dec
  import rbd_pkg::*;
#(
  parameter int unsigned NENT = 16,
  parameter int unsigned AW   = 32
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [MODE_W*NENT-1:0]            ent_mode,
  input  logic [NENT*AW-1:0]                ent_addr,
  output logic [NENT*(AW+2)-1:0]            rgn_lo,
  output logic [NENT*(AW+2)-1:0]            rgn_hi,
  output logic [NENT-1:0]                   rgn_on,
  output logic [$clog2(NENT+1)-1:0]         rule_cnt
);
  localparam int unsigned BW = AW + 2;
  localparam int unsigned CW = $clog2(NENT + 1);

  logic [NENT*BW-1:0] nxt_lo;
  logic [NENT*BW-1:0] nxt_hi;
  logic [NENT-1:0]    nxt_on;
  logic [CW-1:0]      nxt_cnt;

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    logic [AW-1:0] prev_word;

    if (i == 0) begin : g_first
      assign prev_word = '0;  // R2: entry 0 has no predecessor
    end else begin : g_rest
      assign prev_word = ent_addr[(i-1)*AW +: AW];
    end

    rbd_entry_dec #(.AW(AW)) u_dec (
      .mode      (ent_mode[MODE_W*i +: MODE_W]),
      .own_word  (ent_addr[i*AW +: AW]),
      .prev_word (prev_word),
      .lo        (nxt_lo[i*BW +: BW]),
      .hi        (nxt_hi[i*BW +: BW]),
      .on        (nxt_on[i])
    );
  end

  rbd_rule_count #(.NENT(NENT)) u_cnt (
    .on  (nxt_on),
    .cnt (nxt_cnt)
  );

  // R8 / R9: single output register stage with asynchronous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rgn_lo   <= '0;
      rgn_hi   <= '0;
      rgn_on   <= '0;
      rule_cnt <= '0;
    end else begin
      rgn_lo   <= nxt_lo;
      rgn_hi   <= nxt_hi;
      rgn_on   <= nxt_on;
      rule_cnt <= nxt_cnt;
    end
  end
endmodule

// File: rtl/rbd_checker.sv
module rbd_checker #(
  parameter int unsigned NENT = 16,
  parameter int unsigned AW   = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [2*NENT-1:0]         ent_mode,
  input logic [NENT*AW-1:0]        ent_addr,
  input logic [NENT*(AW+2)-1:0]    rgn_lo,
  input logic [NENT*(AW+2)-1:0]    rgn_hi,
  input logic [NENT-1:0]           rgn_on,
  input logic [$clog2(NENT+1)-1:0] rule_cnt
);
  localparam int unsigned BW = AW + 2;

  // Set once a full clock edge has passed out of reset, so $past is defined.
  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rule_cnt == $bits(rule_cnt)'($countones(rgn_on)));

  for (genvar i = 0; i < NENT; i++) begin : g_chk
    logic [BW-1:0] lo, hi, span;
    assign lo   = rgn_lo[i*BW +: BW];
    assign hi   = rgn_hi[i*BW +: BW];
    assign span = hi ^ lo;

    p_off_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(ent_mode[2*i +: 2]) == 2'd0) |-> (!rgn_on[i] && lo == '0 && hi == '0));

    p_enable_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (rgn_on[i] == ($past(ent_mode[2*i +: 2]) != 2'd0)));

    p_ordered_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lo <= hi);

    p_word_span_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(ent_mode[2*i +: 2]) == 2'd2)
        |-> ((hi - lo) == BW'(3) && lo == {$past(ent_addr[i*AW +: AW]), 2'b00}));

    p_pow2_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(ent_mode[2*i +: 2]) == 2'd3)
        |-> ((lo & span) == '0 && ((span + BW'(1)) & span) == '0 && hi[2:0] == 3'b111));
  end
endmodule

bind region_bounds_dec rbd_checker #(.NENT(NENT), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ent_mode (ent_mode),
  .ent_addr (ent_addr),
  .rgn_lo   (rgn_lo),
  .rgn_hi   (rgn_hi),
  .rgn_on   (rgn_on),
  .rule_cnt (rule_cnt)
);

// File: tb/sim_region_bounds_dec.sv
`timescale 1ns/1ps
module sim_region_bounds_dec;
  localparam int NENT = 4;
  localparam int AW   = 6;
  localparam int BW   = AW + 2;
  localparam int CW   = $clog2(NENT + 1);

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [2*NENT-1:0]   ent_mode = '0;
  logic [NENT*AW-1:0]  ent_addr = '0;
  logic [NENT*BW-1:0]  rgn_lo;
  logic [NENT*BW-1:0]  rgn_hi;
  logic [NENT-1:0]     rgn_on;
  logic [CW-1:0]       rule_cnt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [BW-1:0] exp_lo [NENT];
  logic [BW-1:0] exp_hi [NENT];
  logic          exp_on [NENT];
  string         exp_tag[NENT];
  int            exp_cnt;
  logic [31:0]   seed = 32'h1234_5679;

  region_bounds_dec #(.NENT(NENT), .AW(AW)) u0 (
    .clk (clk), .rst_n (rst_n), .ent_mode (ent_mode), .ent_addr (ent_addr),
    .rgn_lo (rgn_lo), .rgn_hi (rgn_hi), .rgn_on (rgn_on), .rule_cnt (rule_cnt)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] rnd(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  // Arithmetic reference for the current input values.
  task automatic compute_expected();
    exp_cnt = 0;
    for (int e = 0; e < NENT; e++) begin
      longint a, p, sz, lo, hi;
      int k, m;
      m = int'(ent_mode[2*e +: 2]);
      a = longint'(ent_addr[e*AW +: AW]);
      p = (e == 0) ? 0 : longint'(ent_addr[(e-1)*AW +: AW]);
      lo = 0; hi = 0;
      exp_on[e] = (m != 0);
      if (m != 0) exp_cnt++;
      case (m)
        0: exp_tag[e] = "R1";
        1: begin
          if (p < a) begin lo = p * 4; hi = a * 4 - 1; exp_tag[e] = "R2"; end
          else exp_tag[e] = "R3";
        end
        2: begin lo = a * 4; hi = lo + 3; exp_tag[e] = "R4"; end
        default: begin
          k = 0;
          while (k < AW && ((a >> k) & 1) == 1) k++;
          sz = longint'(8) << k;
          if (sz > (longint'(1) << BW)) sz = longint'(1) << BW;
          lo = (a * 4) - ((a * 4) % sz);
          hi = lo + sz - 1;
          exp_tag[e] = (sz == (longint'(1) << BW)) ? "R6" : "R5";
        end
      endcase
      exp_lo[e] = BW'(lo);
      exp_hi[e] = BW'(hi);
    end
  endtask

  task automatic check_outputs(input string ctx);
    for (int e = 0; e < NENT; e++) begin
      logic [BW-1:0] glo, ghi;
      glo = rgn_lo[e*BW +: BW];
      ghi = rgn_hi[e*BW +: BW];
      checks++;
      if (glo !== exp_lo[e] || ghi !== exp_hi[e] || rgn_on[e] !== exp_on[e]) begin
        errors++;
        $display("FAIL %s %s entry %0d: got lo=%0h hi=%0h on=%0b expected lo=%0h hi=%0h on=%0b",
                 exp_tag[e], ctx, e, glo, ghi, rgn_on[e], exp_lo[e], exp_hi[e], exp_on[e]);
      end
    end
    checks++;
    if (int'(rule_cnt) != exp_cnt) begin
      errors++;
      $display("FAIL R7 %s: got count=%0d expected %0d", ctx, rule_cnt, exp_cnt);
    end
  endtask

  // Called at a falling edge: drive, wait one rising edge, check at next falling edge.
  task automatic apply(input logic [2*NENT-1:0] m, input logic [NENT*AW-1:0] a, input string ctx);
    ent_mode = m;
    ent_addr = a;
    compute_expected();
    @(negedge clk);
    check_outputs(ctx);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    // R9: outputs stay zero in reset even with live inputs and clock edges
    ent_mode = {NENT{2'd3}};
    ent_addr = {NENT{6'h15}};
    repeat (3) @(negedge clk);
    checks++;
    if (rgn_lo !== '0 || rgn_hi !== '0 || rgn_on !== '0 || rule_cnt !== '0) begin
      errors++;
      $display("FAIL R9 reset: got on=%0b cnt=%0d lo=%0h expected all zero", rgn_on, rule_cnt, rgn_lo);
    end
    rst_n = 1'b1;

    // R6: whole-space regions, no wrap at the top
    apply({2'd3, 2'd3, 2'd0, 2'd0}, {6'h3F, 6'h1F, 6'h00, 6'h00}, "full space");

    // R2 entry 0 with implicit zero predecessor; R3 equal words
    apply({2'd1, 2'd1, 2'd1, 2'd1}, {6'h20, 6'h20, 6'h10, 6'h05}, "tor chain");

    // R8: output holds the previous result until the next rising edge
    ent_mode = {2'd2, 2'd2, 2'd2, 2'd2};
    ent_addr = {6'h01, 6'h02, 6'h03, 6'h04};
    compute_expected();
    @(negedge clk);
    check_outputs("latency load");
    ent_mode = '0;
    ent_addr = '0;
    #2;
    check_outputs("R8 hold before edge");
    compute_expected();
    @(negedge clk);
    check_outputs("R8 update after edge");

    // Near-exhaustive: every mode combination with many address patterns
    for (int mc = 0; mc < (1 << (2*NENT)); mc++) begin
      for (int r = 0; r < 40; r++) begin
        seed = rnd(seed);
        apply((2*NENT)'(mc), (NENT*AW)'(seed), "mode sweep");
      end
    end

    // Every address word in each enabled mode, neighbours offset
    for (int md = 1; md < 4; md++) begin
      for (int v = 0; v < (1 << AW); v++) begin
        logic [NENT*AW-1:0] a;
        for (int e = 0; e < NENT; e++) a[e*AW +: AW] = AW'(v + e * 5);
        apply({NENT{2'(md)}}, a, "word sweep");
      end
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule